// File: doc/BRIEF.md
# First-Fault Capture Module

This block records which fault appeared first in a power system built from several sub-units. It watches a word of digital fault lines and a separate trigger line. The trigger is meant to be the OR of the fault lines. On the first trigger edge after arming, the block stores the fault word. In the same cycle it freezes a free-running timestamp counter. That counter ticks with a fixed period that every module shares. When several modules trip in a cascade, the host reads every frozen timestamp and picks the module with the smallest one as the origin of the trip.

Readout uses a synchronous shift interface. A load strobe copies a frame (capture flag, reserved zeros, fault word, timestamp) into a shift register. Each shift strobe then moves the next bit, most significant first, onto the serial output. The serial input enters at the far end of the register. Up to sixteen modules can therefore form one chain: the host loads all of them at once and clocks through every frame in turn. A re-arm pulse clears the capture and restarts the counter from zero. Before any capture, a readout returns the live counter value.

Top module: `fault_capture_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `cap_flag` is 0, the timestamp is 0 and `sdo` is 0.
- R2: While no capture is held, the timestamp rises by one every `TICK_DIV` clock cycles and wraps from its all-ones value to 0. It starts from 0 at reset or re-arm, and the value read `N` cycles after re-arm is ((N-1)/TICK_DIV) mod 2^TS_W.
- R3: A rising edge on `trig_in` while armed sets `cap_flag` three clock edges after `trig_in` is first sampled high. The fault word stored is `flt_in` as sampled at that same first edge.
- R4: While a capture is held, the timestamp keeps the value it had at the capturing edge.
- R5: While a capture is held, later trigger edges and changes on `flt_in` do not alter the stored word or the timestamp. A trigger that is still high after re-arm does not capture until it falls and rises again.
- R6: A re-arm pulse clears `cap_flag` and the stored fault word, and restarts the timestamp and its prescaler from 0.
- R7: When a re-arm and a trigger edge act on the same clock edge, the re-arm wins and the trigger edge is discarded.
- R8: `rd_load` copies a frame of 8+IN_W+TS_W bits into the shift register. From the top, the frame holds: bit 0 is the capture flag, the next 7 bits are 0, then the fault word from bit IN_W-1 down to bit 0, then the timestamp from its most significant bit down. `sdo` always shows the top bit of the register, and each `rd_shift` moves the next bit up.
- R9: Each shift takes `sdi` into the bottom of the register, so bits shifted in appear on `sdo` exactly one frame length of shifts later.
- R10: `rd_load` takes priority over `rd_shift`. A load on the same edge as a capture stores the state from before the capture (flag 0).
- R11: A frame read before any capture has flag 0, an all-zero fault word and the live timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_in | input | IN_W | Asynchronous fault lines |
| trig_in | input | 1 | Asynchronous trigger, OR of the faults |
| rearm | input | 1 | Synchronous re-arm pulse |
| rd_load | input | 1 | Load readout frame into shift register |
| rd_shift | input | 1 | Advance shift register by one bit |
| sdi | input | 1 | Serial input from the next module in the chain |
| sdo | output | 1 | Serial output, frame MSB first |
| cap_flag | output | 1 | A capture is held |

## Verification
Two events can land on the same clock edge: a re-arm and a synchronised trigger edge, and a readout load and a capture. The bench sets `trig_in` high and pulses `rearm` or `rd_load` exactly two cycles later, so that the strobe meets the trigger edge as it leaves the synchroniser. The checks expect the re-arm to discard the edge (`cap_flag` stays 0), and the load to deliver a frame whose flag is 0 while `cap_flag` has already risen. A behavioural model in the bench applies the same priorities every cycle, and its flag and serial bit are compared with the ports.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    localparam int FCU_IN_W     = 24;
    localparam int FCU_TS_W     = 16;
    localparam int FCU_RSV_W    = 7;
    localparam int FCU_TICK_DIV = 2000;   // 8 us at 250 MHz

    typedef enum logic {
        ARM_WAIT = 1'b0,
        ARM_HELD = 1'b1
    } arm_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_GRAB  = 2'd2
    } cap_action_e;

    function automatic int frame_len(int in_w, int ts_w, int rsv_w);
        return 1 + rsv_w + in_w + ts_w;
    endfunction

endpackage

// File: rtl/fcu_sync.sv
module fcu_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                stage2[i] <= 1'b0;
            end else begin
                stage1[i] <= d[i];
                stage2[i] <= stage1[i];
            end
        end
    end

    assign q = stage2;
endmodule

// File: rtl/fcu_arm_ctl.sv
module fcu_arm_ctl import fcu_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        trig_s,
    input  logic        rearm,
    output cap_action_e act,
    output logic        held,
    output logic        rise
);
    logic       trig_prev;
    arm_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) trig_prev <= 1'b0;
        else     trig_prev <= trig_s;
    end

    assign rise = trig_s & ~trig_prev;

    always_comb begin
        if (rearm)                          act = ACT_CLEAR;
        else if (rise && state_q == ARM_WAIT) act = ACT_GRAB;
        else                                act = ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARM_WAIT;
        end else begin
            case (act)
                ACT_CLEAR: state_q <= ARM_WAIT;
                ACT_GRAB:  state_q <= ARM_HELD;
                default:   state_q <= state_q;
            endcase
        end
    end

    assign held = (state_q == ARM_HELD);
endmodule

// File: rtl/fcu_stamp.sv
module fcu_stamp import fcu_pkg::*; #(
    parameter int TS_W     = FCU_TS_W,
    parameter int TICK_DIV = FCU_TICK_DIV
) (
    input  logic            clk,
    input  logic            rst,
    input  cap_action_e     act,
    input  logic            run,
    output logic [TS_W-1:0] stamp
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [TS_W-1:0]  ts_q;

    always_ff @(posedge clk) begin
        if (rst || act == ACT_CLEAR) begin
            pre_q <= '0;
            ts_q  <= '0;
        end else if (run && act != ACT_GRAB) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                ts_q  <= ts_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign stamp = ts_q;
endmodule

// File: rtl/fcu_shift.sv
module fcu_shift #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par,
    input  logic         sdi,
    output logic         sdo
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= '0;
        else if (load)  sh_q <= par;
        else if (shift) sh_q <= {sh_q[W-2:0], sdi};
    end

    assign sdo = sh_q[W-1];
endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit import fcu_pkg::*; #(
    parameter int IN_W     = FCU_IN_W,
    parameter int TS_W     = FCU_TS_W,
    parameter int RSV_W    = FCU_RSV_W,
    parameter int TICK_DIV = FCU_TICK_DIV
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] flt_in,
    input  logic            trig_in,
    input  logic            rearm,
    input  logic            rd_load,
    input  logic            rd_shift,
    input  logic            sdi,
    output logic            sdo,
    output logic            cap_flag
);
    localparam int FRAME_W = frame_len(IN_W, TS_W, RSV_W);

    logic [IN_W-1:0]    flt_s;
    logic               trig_s;
    logic               trig_rise;
    logic               held;
    cap_action_e        act;
    logic [TS_W-1:0]    ts_val;
    logic [IN_W-1:0]    snap_q;
    logic [FRAME_W-1:0] frame;

    fcu_sync #(.W(IN_W)) u_flt_sync (
        .clk(clk), .rst(rst), .d(flt_in), .q(flt_s)
    );

    fcu_sync #(.W(1)) u_trig_sync (
        .clk(clk), .rst(rst), .d(trig_in), .q(trig_s)
    );

    fcu_arm_ctl u_arm (
        .clk(clk), .rst(rst), .trig_s(trig_s), .rearm(rearm),
        .act(act), .held(held), .rise(trig_rise)
    );

    fcu_stamp #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_stamp (
        .clk(clk), .rst(rst), .act(act), .run(~held), .stamp(ts_val)
    );

    always_ff @(posedge clk) begin
        if (rst || act == ACT_CLEAR) snap_q <= '0;
        else if (act == ACT_GRAB)    snap_q <= flt_s;
    end

    assign frame = {held, {RSV_W{1'b0}}, snap_q, ts_val};

    fcu_shift #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .load(rd_load), .shift(rd_shift),
        .par(frame), .sdi(sdi), .sdo(sdo)
    );

    assign cap_flag = held;
endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
    parameter int IN_W = 24,
    parameter int TS_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            rearm,
    input logic            rd_load,
    input logic            sdo,
    input logic            cap_flag,
    input logic            rise,
    input logic [TS_W-1:0] stamp,
    input logic [IN_W-1:0] snap
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cap_flag && stamp == '0));

    assert_stamp_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!cap_flag && !rearm) |=>
        (stamp == $past(stamp) || stamp == $past(stamp) + TS_W'(1)));

    assert_edge_grabs_R3: assert property (@(posedge clk) disable iff (rst)
        (rise && !cap_flag && !rearm) |=> cap_flag);

    assert_stamp_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !rearm) |=> $stable(stamp));

    assert_later_edge_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !rearm) |=> (cap_flag && $stable(snap)));

    assert_rearm_clears_R6: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (!cap_flag && stamp == '0 && snap == '0));

    assert_rearm_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (rearm && rise) |=> !cap_flag);

    assert_load_flag_first_R8: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> (sdo == $past(cap_flag)));
endmodule

bind fault_capture_unit fcu_checker #(.IN_W(IN_W), .TS_W(TS_W)) chk_i (
    .clk(clk), .rst(rst), .rearm(rearm), .rd_load(rd_load), .sdo(sdo),
    .cap_flag(cap_flag), .rise(trig_rise), .stamp(ts_val), .snap(snap_q)
);

// File: tb/fault_capture_unit_tb_top.sv
module fault_capture_unit_tb_top;
    localparam int IN_W = 24;
    localparam int TS_W = 10;
    localparam int RSV_W = 7;
    localparam int DIV  = 3;
    localparam int FW   = 1 + RSV_W + IN_W + TS_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IN_W-1:0] flt_in = '0;
    logic            trig_in = 1'b0;
    logic            rearm = 1'b0;
    logic            rd_load = 1'b0;
    logic            rd_shift = 1'b0;
    logic            sdi = 1'b0;
    logic            sdo;
    logic            cap_flag;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    fault_capture_unit #(.IN_W(IN_W), .TS_W(TS_W), .RSV_W(RSV_W), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .flt_in(flt_in), .trig_in(trig_in), .rearm(rearm),
        .rd_load(rd_load), .rd_shift(rd_shift), .sdi(sdi), .sdo(sdo), .cap_flag(cap_flag)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_cap;
    int          m_ts, m_pre;
    bit [IN_W-1:0] m_snap;
    bit [FW-1:0] m_sh, m_loaded, m_frame;
    bit          th[3];
    bit [IN_W-1:0] fh[2];
    bit          m_rise;

    always @(posedge clk) begin
        if (rst) begin
            m_cap = 0; m_ts = 0; m_pre = 0; m_snap = '0; m_sh = '0;
            th[0] = 0; th[1] = 0; th[2] = 0; fh[0] = '0; fh[1] = '0;
        end else begin
            m_rise  = th[1] && !th[2];
            m_frame = {m_cap, {RSV_W{1'b0}}, m_snap, TS_W'(m_ts)};
            if (rd_load) begin
                m_sh = m_frame; m_loaded = m_frame;
            end else if (rd_shift) begin
                m_sh = {m_sh[FW-2:0], sdi};
            end
            if (rearm) begin
                m_cap = 0; m_snap = '0; m_ts = 0; m_pre = 0;
            end else if (m_rise && !m_cap) begin
                m_cap = 1; m_snap = fh[1];
            end else if (!m_cap) begin
                m_pre++;
                if (m_pre == DIV) begin
                    m_pre = 0;
                    m_ts = (m_ts + 1) % (1 << TS_W);
                end
            end
            th[2] = th[1]; th[1] = th[0]; th[0] = trig_in;
            fh[1] = fh[0]; fh[0] = flt_in;
        end
    end

    always @(negedge clk) begin
        chk("R3 R5 R6 model cap_flag", 64'(cap_flag), 64'(m_cap));
        chk("R8 R9 model sdo", 64'(sdo), 64'(m_sh[FW-1]));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load();
        rd_load = 1'b1; tick(1); rd_load = 1'b0;
    endtask

    task automatic shift_out(input int n, input logic [63:0] din, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            got[n-1-i] = sdo;
            sdi = din[n-1-i];
            rd_shift = 1'b1;
            tick(1);
        end
        rd_shift = 1'b0;
        sdi = 1'b0;
    endtask

    logic [63:0] fr, fr2, din;
    logic [TS_W-1:0] held_ts;

    initial begin
        // R1: reset state
        tick(3);
        chk("R1 cap_flag in reset", 64'(cap_flag), 64'd0);
        chk("R1 sdo in reset", 64'(sdo), 64'd0);
        rst = 1'b0;
        tick(1);
        chk("R1 cap_flag after reset", 64'(cap_flag), 64'd0);

        // R11: read before capture
        tick(30);
        do_load();
        shift_out(FW, '0, fr);
        chk("R11 flag before capture", 64'(fr[FW-1]), 64'd0);
        chk("R11 inputs zero before capture", 64'(fr[TS_W +: IN_W]), 64'd0);
        chk("R11 live stamp", 64'(fr[TS_W-1:0]), 64'(m_loaded[TS_W-1:0]));

        // R2: rate and wrap, N cycles after re-arm
        rearm = 1'b1; tick(1); rearm = 1'b0;
        tick(3100 - 1);
        do_load();
        shift_out(FW, '0, fr);
        chk("R2 stamp after wrap", 64'(fr[TS_W-1:0]), 64'(((3100 - 1) / DIV) % (1 << TS_W)));
        rearm = 1'b1; tick(1); rearm = 1'b0;
        tick(30 - 1);
        do_load();
        shift_out(FW, '0, fr);
        chk("R2 stamp rate", 64'(fr[TS_W-1:0]), 64'((30 - 1) / DIV));

        // R3: capture latency and snapshot
        flt_in = 24'hA5C3_11;
        tick(2);
        trig_in = 1'b1;
        tick(2);
        chk("R3 no flag two edges after trigger", 64'(cap_flag), 64'd0);
        tick(1);
        chk("R3 flag on third edge", 64'(cap_flag), 64'd1);
        flt_in = 24'h0F0F0F;
        tick(5);
        do_load();
        shift_out(FW, '0, fr);
        chk("R3 frame flag", 64'(fr[FW-1]), 64'd1);
        chk("R8 reserved zero", 64'(fr[IN_W+TS_W +: RSV_W]), 64'd0);
        chk("R3 snapshot word", 64'(fr[TS_W +: IN_W]), 64'h A5C311);
        held_ts = fr[TS_W-1:0];

        // R4: stamp frozen
        tick(60);
        do_load();
        shift_out(FW, '0, fr2);
        chk("R4 stamp frozen", 64'(fr2[TS_W-1:0]), 64'(held_ts));

        // R5: later edge ignored
        trig_in = 1'b0; tick(4);
        flt_in = 24'h123456;
        trig_in = 1'b1; tick(8);
        do_load();
        shift_out(FW, '0, fr2);
        chk("R5 snapshot kept", 64'(fr2[TS_W +: IN_W]), 64'h A5C311);
        chk("R5 stamp kept", 64'(fr2[TS_W-1:0]), 64'(held_ts));

        // R6: re-arm with trigger still high
        rearm = 1'b1; tick(1); rearm = 1'b0;
        chk("R6 flag cleared", 64'(cap_flag), 64'd0);
        tick(10);
        chk("R5 high trigger no recapture", 64'(cap_flag), 64'd0);
        do_load();
        shift_out(FW, '0, fr);
        chk("R6 snapshot cleared", 64'(fr[TS_W +: IN_W]), 64'd0);
        chk("R6 stamp restarted", 64'(fr[TS_W-1:0]), 64'((11 - 1) / DIV));

        // R7: re-arm on the same edge as the trigger edge
        trig_in = 1'b0; tick(4);
        trig_in = 1'b1; tick(2);
        rearm = 1'b1; tick(1); rearm = 1'b0;
        tick(10);
        chk("R7 edge discarded by re-arm", 64'(cap_flag), 64'd0);

        // R10: load on the capture edge, then load with shift
        trig_in = 1'b0; tick(4);
        flt_in = 24'h00FF01;
        trig_in = 1'b1; tick(2);
        rd_load = 1'b1; tick(1); rd_load = 1'b0;
        chk("R10 capture happened", 64'(cap_flag), 64'd1);
        chk("R10 loaded pre-capture flag", 64'(sdo), 64'd0);
        rd_load = 1'b1; rd_shift = 1'b1; tick(1);
        rd_load = 1'b0; rd_shift = 1'b0;
        chk("R10 load beats shift", 64'(sdo), 64'd1);

        // R9: chain pass-through
        din = 64'h0;
        din[FW +: 8] = 8'hB4;
        do_load();
        shift_out(FW + 8, din, fr);
        chk("R9 sdi emerges after one frame", 64'(fr[7:0]), 64'h B4);
        chk("R8 frame word after load", 64'(fr[8 + TS_W +: IN_W]), 64'h00FF01);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule